// File: doc/BRIEF.md
# Frame-Synchronized Three-Slot Serial Shifter

This block moves the leading three 16-bit slots of every serial frame between a codec and the parallel side of a chip. It runs on the codec's serial clock. A frame-sync pulse opens a shift window. During the window a 48-bit transmit chain (control word, then left sample, then right sample) is sent MSB first on the rising edges. In parallel, a 48-bit receive chain captures the codec's data on the falling edges. After 48 bit times both chains stop. The block raises a one-cycle `rx_valid` strobe and holds the received words until the next window.

Outside the window the transmit chain accepts a parallel load of all three words in one beat. The load port is valid/ready. `load_ready` is high only while the window is closed, so a producer that holds `load_valid` simply waits out the window. The receive side has no back-pressure, because a codec cannot be stalled. The consumer must read `rx_ctl`, `rx_left` and `rx_right` before the next frame sync, and they stay constant until then. The tail of the transmit chain is fed a constant 1, so every bit sent after the 48th is a 1 until the next load.

Top module: `ss_slot_shifter`

## Requirements
- R1: A high `fsync` at a rising edge makes `shift_sel` high from that edge on and drives `load_ready` low.
- R2: A window lasts exactly 48 rising edges after the frame-sync edge. `shift_sel` falls at the 48th. While the window is closed the bit count stays cleared, so every new frame again gets a full 48 bits.
- R3: `sdo` shows transmit bit 47 of {control, left, right} after the frame-sync edge. Each later rising edge in the window moves to the next lower bit. So the control word goes out MSB first, then the left word, then the right word.
- R4: From the 48th shift until the next accepted load, `sdo` is 1.
- R5: `sdi` is sampled on the 48 falling edges that follow the frame-sync edge, MSB first. The first sample lands in `rx_ctl[15]`, the 17th in `rx_left[15]` and the 48th in `rx_right[0]`.
- R6: `rx_valid` is high for exactly the one cycle that follows the 48th rising edge. While `shift_sel` is low, the receive words do not change.
- R7: The words on `load_ctl/load_left/load_right` are taken at a rising edge where `load_valid` and `load_ready` are both high. A `load_valid` while `shift_sel` is high has no effect on `sdo`.
- R8: A `fsync` during an open window restarts the count from zero. No bit is shifted at that edge, and 48 further shifts follow.
- R9: A synchronous `rst` closes the window, clears the count, drives `sdo` to 0 and clears all receive words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Codec serial clock |
| rst | input | 1 | Synchronous reset, active high |
| fsync | input | 1 | Frame sync from the codec |
| sdi | input | 1 | Serial data from the codec |
| sdo | output | 1 | Serial data to the codec |
| load_valid | input | 1 | Parallel transmit words offered |
| load_ready | output | 1 | Load accepted (window closed) |
| load_ctl | input | 16 | Control word to send in slot 1 |
| load_left | input | 16 | Left sample to send in slot 2 |
| load_right | input | 16 | Right sample to send in slot 3 |
| shift_sel | output | 1 | High while frame bits are exchanged (shift), low for parallel load |
| rx_valid | output | 1 | One-cycle strobe when the window closes |
| rx_ctl | output | 16 | Received slot 1 word |
| rx_left | output | 16 | Received slot 2 word |
| rx_right | output | 16 | Received slot 3 word |

## Verification
A bit counter that is off by one shows up at the ports within one frame. The edge on which `shift_sel` falls and the `rx_valid` strobe move by a cycle. The last received bit is either lost or doubled, which shifts `rx_right` by one position. A stuck or wrongly gated transmit chain shows on `sdo` in the very first bit time after the load: the wrong MSB, a missing fill of ones after bit 48, or a load taking effect inside a window. A receive chain that keeps capturing after the window changes the received words on the next idle cycle. The reference model compares every output on every cycle, so each of these faults is reported in the cycle where it first appears.

// File: rtl/ss_pkg.sv
package ss_pkg;
  localparam int unsigned SS_SLOT_W_DEF = 16;
  localparam int unsigned SS_SLOTS      = 3;

  function automatic int unsigned ss_cnt_bits(input int unsigned total);
    return $clog2(total + 1);
  endfunction
endpackage

// File: rtl/ss_bitcount.sv
module ss_bitcount #(
  parameter int unsigned TOTAL = 48,
  localparam int unsigned CW   = ss_pkg::ss_cnt_bits(TOTAL)
) (
  input  logic clk,
  input  logic rst,
  input  logic fsync,
  output logic run,
  output logic expiry,
  output logic shift_en
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      run <= 1'b0;
      cnt <= '0;
    end else if (fsync) begin
      run <= 1'b1;
      cnt <= '0;
    end else if (run) begin
      cnt <= cnt + 1'b1;
      if (cnt == CW'(TOTAL - 1)) run <= 1'b0;
    end else begin
      cnt <= '0;
    end
  end

  assign expiry   = (cnt == CW'(TOTAL)) && !run;
  assign shift_en = run && !fsync;
endmodule

// File: rtl/ss_txchain.sv
module ss_txchain #(
  parameter int unsigned W = 48
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load_en,
  input  logic [W-1:0] load_word,
  input  logic         shift_en,
  output logic         sdo
);
  logic [W-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst)           chain <= '0;
    else if (load_en)  chain <= load_word;
    else if (shift_en) chain <= {chain[W-2:0], 1'b1};
  end

  assign sdo = chain[W-1];
endmodule

// File: rtl/ss_rxchain.sv
module ss_rxchain #(
  parameter int unsigned W = 48
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         cap_en,
  input  logic         sdi,
  output logic [W-1:0] word
);
  always_ff @(negedge clk) begin
    if (rst)         word <= '0;
    else if (cap_en) word <= {word[W-2:0], sdi};
  end
endmodule

// File: rtl/ss_slot_shifter.sv
module ss_slot_shifter #(
  parameter int unsigned SLOT_W = ss_pkg::SS_SLOT_W_DEF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fsync,
  input  logic              sdi,
  output logic              sdo,
  input  logic              load_valid,
  output logic              load_ready,
  input  logic [SLOT_W-1:0] load_ctl,
  input  logic [SLOT_W-1:0] load_left,
  input  logic [SLOT_W-1:0] load_right,
  output logic              shift_sel,
  output logic              rx_valid,
  output logic [SLOT_W-1:0] rx_ctl,
  output logic [SLOT_W-1:0] rx_left,
  output logic [SLOT_W-1:0] rx_right
);
  localparam int unsigned SLOTS = ss_pkg::SS_SLOTS;
  localparam int unsigned TOTAL = SLOTS * SLOT_W;

  logic             run;
  logic             expiry;
  logic             shift_en;
  logic [TOTAL-1:0] tx_word;
  logic [TOTAL-1:0] rx_word;
  logic [SLOT_W-1:0] rx_slot [SLOTS];

  ss_bitcount #(.TOTAL(TOTAL)) u_cnt (
    .clk(clk), .rst(rst), .fsync(fsync),
    .run(run), .expiry(expiry), .shift_en(shift_en)
  );

  assign tx_word = {load_ctl, load_left, load_right};

  ss_txchain #(.W(TOTAL)) u_tx (
    .clk(clk), .rst(rst), .load_en(load_valid && !run),
    .load_word(tx_word), .shift_en(shift_en), .sdo(sdo)
  );

  ss_rxchain #(.W(TOTAL)) u_rx (
    .clk(clk), .rst(rst), .cap_en(run), .sdi(sdi), .word(rx_word)
  );

  // slot 0 is the first received (most significant) word
  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    assign rx_slot[g] = rx_word[TOTAL-1-g*SLOT_W -: SLOT_W];
  end

  assign rx_ctl     = rx_slot[0];
  assign rx_left    = rx_slot[1];
  assign rx_right   = rx_slot[2];
  assign shift_sel  = run;
  assign load_ready = !run;
  assign rx_valid   = expiry;
endmodule

// File: rtl/ss_slot_shifter_chk.sv
module ss_slot_shifter_chk #(
  parameter int unsigned SLOT_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              fsync,
  input logic              sdo,
  input logic              load_valid,
  input logic              load_ready,
  input logic [SLOT_W-1:0] load_ctl,
  input logic              shift_sel,
  input logic              rx_valid,
  input logic [SLOT_W-1:0] rx_ctl,
  input logic [SLOT_W-1:0] rx_left,
  input logic [SLOT_W-1:0] rx_right
);
  assert_start_R1: assert property (@(posedge clk) disable iff (rst)
    fsync |=> shift_sel);

  assert_closed_R2: assert property (@(posedge clk) disable iff (rst)
    rx_valid |-> (!shift_sel && load_ready));

  assert_fill_R4: assert property (@(posedge clk) disable iff (rst)
    rx_valid |-> sdo);

  assert_pulse_R6: assert property (@(posedge clk) disable iff (rst)
    rx_valid |=> !rx_valid);

  assert_hold_R6: assert property (@(posedge clk) disable iff (rst)
    !rst |=> (shift_sel || ($stable(rx_ctl) && $stable(rx_left) && $stable(rx_right))));

  assert_load_R7: assert property (@(posedge clk) disable iff (rst)
    (load_valid && load_ready) |=> (sdo == $past(load_ctl[SLOT_W-1])));

  assert_restart_R8: assert property (@(posedge clk) disable iff (rst)
    (fsync && shift_sel) |=> (shift_sel && !rx_valid));
endmodule

bind ss_slot_shifter ss_slot_shifter_chk #(.SLOT_W(SLOT_W)) u_chk (
  .clk(clk), .rst(rst), .fsync(fsync), .sdo(sdo),
  .load_valid(load_valid), .load_ready(load_ready), .load_ctl(load_ctl),
  .shift_sel(shift_sel), .rx_valid(rx_valid),
  .rx_ctl(rx_ctl), .rx_left(rx_left), .rx_right(rx_right)
);

// File: tb/sim_ss_slot_shifter.sv
`timescale 1ns/1ps
module sim_ss_slot_shifter;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic fsync = 1'b0;
  logic sdi = 1'b0;
  logic sdo;
  logic load_valid = 1'b0;
  logic load_ready;
  logic [15:0] load_ctl = '0, load_left = '0, load_right = '0;
  logic shift_sel, rx_valid;
  logic [15:0] rx_ctl, rx_left, rx_right;

  always #4 clk = ~clk;

  ss_slot_shifter u0 (
    .clk(clk), .rst(rst), .fsync(fsync), .sdi(sdi), .sdo(sdo),
    .load_valid(load_valid), .load_ready(load_ready),
    .load_ctl(load_ctl), .load_left(load_left), .load_right(load_right),
    .shift_sel(shift_sel), .rx_valid(rx_valid),
    .rx_ctl(rx_ctl), .rx_left(rx_left), .rx_right(rx_right)
  );

  int n_cmp = 0;
  int n_bad = 0;

  // reference model state
  bit        m_run = 0;
  int        m_cnt = 0;
  bit [47:0] m_tx = '0;
  bit [47:0] m_rx = '0;
  bit [47:0] src = '0;

  task automatic cmp(input string req, input string what,
                     input logic [47:0] act, input logic [47:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  task automatic step(input bit rs, input bit fs, input bit lv,
                      input bit [15:0] c, input bit [15:0] l, input bit [15:0] r,
                      input bit din);
    bit old_run;
    rst = rs; fsync = fs; load_valid = lv;
    load_ctl = c; load_left = l; load_right = r; sdi = din;
    @(negedge clk);
    if (rs) m_rx = '0;
    else if (m_run) m_rx = {m_rx[46:0], din};
    @(posedge clk);
    #1;
    old_run = m_run;
    if (rs) begin
      m_run = 0; m_cnt = 0; m_tx = '0;
    end else if (fs) begin
      if (lv && !old_run) m_tx = {c, l, r};
      m_run = 1; m_cnt = 0;
    end else if (old_run) begin
      m_tx = {m_tx[46:0], 1'b1};
      m_cnt++;
      if (m_cnt == 48) m_run = 0;
    end else begin
      m_cnt = 0;
      if (lv) m_tx = {c, l, r};
    end
    if (rs) begin
      cmp("R9", "sdo", 48'(sdo), 48'(m_tx[47]));
      cmp("R9", "shift_sel", 48'(shift_sel), 48'(m_run));
      cmp("R9", "rx_words", {rx_ctl, rx_left, rx_right}, m_rx);
    end else begin
      cmp(m_run ? "R3" : "R4", "sdo", 48'(sdo), 48'(m_tx[47]));
      cmp(fs && old_run ? "R8" : (old_run && !m_run ? "R2" : "R1"),
          "shift_sel", 48'(shift_sel), 48'(m_run));
      cmp("R7", "load_ready", 48'(load_ready), 48'(!m_run));
      cmp("R6", "rx_valid", 48'(rx_valid), 48'(!m_run && m_cnt == 48));
      cmp("R5", "rx_words", {rx_ctl, rx_left, rx_right}, m_rx);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, '0, '0, '0, 1'b0);
  endtask

  task automatic bits(input int n);
    for (int i = 0; i < n; i++) begin
      step(0, 0, 0, '0, '0, '0, src[47]);
      src = {src[46:0], src[47]};
    end
  endtask

  initial begin
    repeat (2000) @(posedge clk);
    n_bad++;
    $display("FAIL R2 watchdog act=running exp=finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    @(posedge clk); #1;
    // R9: reset state
    for (int i = 0; i < 3; i++) step(1, 0, 0, '0, '0, '0, 1'b1);
    idle(2);
    // R7: load while closed, R1/R3/R5 first frame
    step(0, 0, 1, 16'hA5C3, 16'h1234, 16'hFE01, 1'b0);
    idle(2);
    src = 48'hC0DE_8001_7FFE;
    step(0, 1, 0, '0, '0, '0, 1'b0);
    bits(10);
    // R7: load during the window is ignored
    for (int i = 0; i < 3; i++) begin
      step(0, 0, 1, 16'h0000, 16'h0000, 16'h0000, src[47]);
      src = {src[46:0], src[47]};
    end
    bits(35);
    // R4/R6: fill ones and held receive words
    idle(12);
    // R8: restart mid-window; frame-sync edge also takes a load
    src = 48'h5A5A_F00F_0001;
    step(0, 1, 1, 16'h8001, 16'h00FF, 16'h3C3C, 1'b0);
    bits(20);
    src = 48'h9E37_79B9_4A7C;
    step(0, 1, 1, 16'hFFFF, 16'hFFFF, 16'hFFFF, 1'b0);
    bits(48);
    idle(5);
    // third frame without a new load: all-ones transmit
    src = 48'h0000_FFFF_1248;
    step(0, 1, 0, '0, '0, '0, 1'b1);
    bits(48);
    idle(4);
    // R9: reset in the middle of a window
    step(0, 1, 1, 16'h7777, 16'h1111, 16'h2222, 1'b0);
    bits(5);
    step(1, 0, 0, '0, '0, '0, 1'b1);
    idle(3);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule